// File: doc/BRIEF.md
# Reconfiguration-on-demand task controller

This block sits between a memory-mapped system bus and a single reconfigurable region that can hold one hardware task image at a time. Every task owns a fixed window of word registers on the bus. Software drives each task as if it were fixed hardware. The controller keeps a per-task state and treats a write to a task whose image is not resident like a cache miss. It captures the write and queues a load request for that task. It then pulses a block interrupt so the host can suspend the calling thread.

Loads are started one at a time through a start/done handshake with an external configuration engine. When a load completes, the captured write is replayed into the region and an unblock interrupt is pulsed. When a running task signals that it has finished, the controller copies the region's result registers into a per-task shadow file. Reads of tasks that are no longer resident are then served from that shadow file, so results stay readable after the task has been evicted.

Top module: `recfg_task_ctrl`

## Requirements
- R1: After synchronous reset every task is unloaded, the request queue is empty, and the outputs rgn_wr, cfg_start, blk_irq, unblk_irq and bus_rvalid are low.
- R2: A write to the resident task while it is RUNNING or DONE appears on rgn_wr one cycle later, with rgn_waddr equal to bus_addr[REG_W-1:0] and the same data, and raises no interrupt and no load. A bus address splits into task index bus_addr[ADDR_W-1:REG_W] and register index bus_addr[REG_W-1:0].
- R3: A write to an UNLOADED task pulses blk_irq high for one cycle, one cycle after the write, with blk_task holding the task index, and captures the write.
- R4: If that write arrives while the region is free (nothing resident, or the resident task DONE) and the queue is empty, cfg_start pulses in the same cycle as blk_irq with cfg_task equal to the task, and the task goes to LOADING. Otherwise the task is queued in WAITING.
- R5: Whenever the region is free and the queue is not empty, the head of the queue is popped and its load is started one cycle later. A DONE resident task is evicted to UNLOADED. Loads start in the order the misses arrived.
- R6: cfg_done during a load pulses unblk_irq one cycle later with unblk_task set, moves the task to RUNNING, and replays the task's captured write on rgn_wr in that same cycle.
- R7: rgn_fin while the resident task is RUNNING copies all of rgn_result into that task's shadow registers and moves the task to DONE.
- R8: A write to a DONE resident task moves it back to RUNNING with no new load. In the same cycle it takes priority over dispatching a queued request.
- R9: A read returns data one cycle later with bus_rvalid high. The data comes from rgn_result when the task is LOADING, RUNNING or DONE, and from its shadow registers otherwise. Reads change no task state.
- R10: A write to a task already WAITING or LOADING adds no second queue entry and raises no interrupt. It overwrites that task's single capture slot, so the last such write is the one replayed. The queue never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Word address: task index above register index |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| rgn_wr | output | 1 | Write strobe into the region |
| rgn_waddr | output | REG_W | Register index of the region write |
| rgn_wdata | output | DATA_W | Region write data |
| rgn_result | input | REGS*DATA_W | Result registers of the resident task, register 0 in the low word |
| rgn_fin | input | 1 | Completion pulse from the resident task |
| cfg_start | output | 1 | One-cycle pulse starting a configuration load |
| cfg_task | output | TASK_W | Task index of the load being started |
| cfg_done | input | 1 | Configuration engine finished the load |
| blk_irq | output | 1 | One-cycle block interrupt |
| blk_task | output | TASK_W | Task index of the last block interrupt |
| unblk_irq | output | 1 | One-cycle unblock interrupt |
| unblk_task | output | TASK_W | Task index of the last unblock interrupt |

## Verification
The main function is tried with three write patterns. The first is a miss into an idle region, which must start a load at once. The second is a miss while another load runs, which must only queue. The third is a chain of misses to several tasks, which must load strictly in arrival order with no duplicate load. Repeated writes to a task that is waiting or loading show that only the last captured write is replayed. Reads are swept over every task and register with the region's result lines deliberately changed. The value returned then separates data coming from the region from data coming from the shadow file, and shows which copy survived each eviction.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    ST_UNLOADED = 3'd0,
    ST_WAITING  = 3'd1,
    ST_LOADING  = 3'd2,
    ST_RUNNING  = 3'd3,
    ST_DONE     = 3'd4
  } task_st_e;
endpackage

// File: rtl/rtc_req_fifo.sv
module rtc_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW:0]   CAP  = (PW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CAP);

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rtc_capture.sv
module rtc_capture #(
  parameter int TASKS  = 4,
  parameter int REG_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_en,
  input  logic [$clog2(TASKS)-1:0]  set_idx,
  input  logic [REG_W-1:0]          set_reg,
  input  logic [DATA_W-1:0]         set_data,
  input  logic                      clr_en,
  input  logic [$clog2(TASKS)-1:0]  clr_idx,
  input  logic [$clog2(TASKS)-1:0]  rd_idx,
  output logic                      rd_vld,
  output logic [REG_W-1:0]          rd_reg,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int TW = $clog2(TASKS);

  logic [REG_W-1:0]  reg_q  [TASKS];
  logic [DATA_W-1:0] data_q [TASKS];
  logic [TASKS-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (set_en) begin
      reg_q[set_idx]  <= set_reg;
      data_q[set_idx] <= set_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < TASKS; i++) begin
        if (clr_en && clr_idx == TW'(i))      vld_q[i] <= 1'b0;
        else if (set_en && set_idx == TW'(i)) vld_q[i] <= 1'b1;
      end
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_reg  = reg_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int TASKS  = 4,
  parameter int REGS   = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(TASKS)-1:0] wr_idx,
  input  logic [REGS*DATA_W-1:0]   wr_words,
  input  logic                     rd_en,
  input  logic [$clog2(TASKS)-1:0] rd_idx,
  input  logic [$clog2(REGS)-1:0]  rd_reg,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int RW = $clog2(REGS);

  logic [REGS*DATA_W-1:0] q_flat;
  logic [RW-1:0]          sel_q;

  for (genvar g = 0; g < REGS; g++) begin : g_bank
    logic [DATA_W-1:0] bank [TASKS];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en) bank[wr_idx] <= wr_words[g*DATA_W +: DATA_W];
      if (rd_en) q <= bank[rd_idx];
    end
    assign q_flat[g*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= rd_reg;
  end

  assign rd_data = q_flat[sel_q*DATA_W +: DATA_W];
endmodule

// File: rtl/recfg_task_ctrl.sv
module recfg_task_ctrl
  import rtc_pkg::*;
#(
  parameter int TASKS  = 4,
  parameter int REGS   = 4,
  parameter int DATA_W = 32,
  localparam int TASK_W = $clog2(TASKS),
  localparam int REG_W  = $clog2(REGS),
  localparam int ADDR_W = TASK_W + REG_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_rvalid,
  output logic                   rgn_wr,
  output logic [REG_W-1:0]       rgn_waddr,
  output logic [DATA_W-1:0]      rgn_wdata,
  input  logic [REGS*DATA_W-1:0] rgn_result,
  input  logic                   rgn_fin,
  output logic                   cfg_start,
  output logic [TASK_W-1:0]      cfg_task,
  input  logic                   cfg_done,
  output logic                   blk_irq,
  output logic [TASK_W-1:0]      blk_task,
  output logic                   unblk_irq,
  output logic [TASK_W-1:0]      unblk_task
);
  localparam logic [TASK_W:0] N_TASKS = (TASK_W+1)'(TASKS);

  task_st_e [TASKS-1:0] state_q;
  logic [TASK_W-1:0] res_q;
  logic              res_vld_q;

  // address decode
  logic [TASK_W-1:0] a_task;
  logic [REG_W-1:0]  a_reg;
  logic              a_in;
  logic              wr_v, rd_v;
  task_st_e          st_w, st_res;

  assign a_task = bus_addr[ADDR_W-1:REG_W];
  assign a_reg  = bus_addr[REG_W-1:0];
  assign a_in   = ({1'b0, a_task} < N_TASKS);
  assign wr_v   = bus_wr && a_in;
  assign rd_v   = bus_rd && a_in;
  assign st_w   = state_q[a_task];
  assign st_res = state_q[res_q];

  // event decode
  logic hit_res, hit_done, pass, region_free;
  logic miss, direct, push_req, push, pop, launch;
  logic load_ok, fin_ok, cap_set, fwd;
  logic [TASK_W-1:0] launch_task;
  logic fifo_empty, fifo_full;
  logic [TASK_W-1:0] fifo_head;
  logic cap_vld;
  logic [REG_W-1:0]  cap_reg;
  logic [DATA_W-1:0] cap_data;
  logic [DATA_W-1:0] sh_data;

  assign hit_res     = wr_v && res_vld_q && (a_task == res_q);
  assign hit_done    = hit_res && (st_res == ST_DONE);
  assign pass        = hit_res && (st_res == ST_RUNNING || st_res == ST_DONE);
  assign region_free = (!res_vld_q || st_res == ST_DONE) && !hit_done;
  assign miss        = wr_v && (st_w == ST_UNLOADED);
  assign direct      = miss && region_free && fifo_empty;
  assign push_req    = miss && !direct;
  assign push        = push_req && !fifo_full;
  assign pop         = region_free && !fifo_empty;
  assign launch      = pop || direct;
  assign launch_task = pop ? fifo_head : a_task;
  assign load_ok     = cfg_done && res_vld_q && (st_res == ST_LOADING);
  assign fin_ok      = rgn_fin && res_vld_q && (st_res == ST_RUNNING);
  assign fwd         = hit_res && (st_res == ST_LOADING);
  assign cap_set     = wr_v && (st_w == ST_UNLOADED || st_w == ST_WAITING ||
                                st_w == ST_LOADING);

  rtc_req_fifo #(.DEPTH(TASKS), .W(TASK_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(a_task),
    .pop(pop), .head(fifo_head),
    .empty(fifo_empty), .full(fifo_full)
  );

  rtc_capture #(.TASKS(TASKS), .REG_W(REG_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst),
    .set_en(cap_set), .set_idx(a_task), .set_reg(a_reg), .set_data(bus_wdata),
    .clr_en(load_ok), .clr_idx(res_q),
    .rd_idx(res_q), .rd_vld(cap_vld), .rd_reg(cap_reg), .rd_data(cap_data)
  );

  rtc_shadow #(.TASKS(TASKS), .REGS(REGS), .DATA_W(DATA_W)) u_shadow (
    .clk(clk),
    .wr_en(fin_ok), .wr_idx(res_q), .wr_words(rgn_result),
    .rd_en(rd_v), .rd_idx(a_task), .rd_reg(a_reg), .rd_data(sh_data)
  );

  // task state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TASKS; i++) state_q[i] <= ST_UNLOADED;
      res_q     <= '0;
      res_vld_q <= 1'b0;
    end else begin
      for (int i = 0; i < TASKS; i++) begin
        if (launch && launch_task == TASK_W'(i))
          state_q[i] <= ST_LOADING;
        else if (launch && res_vld_q && res_q == TASK_W'(i))
          state_q[i] <= ST_UNLOADED;
        else if (push && a_task == TASK_W'(i))
          state_q[i] <= ST_WAITING;
        else if (fin_ok && res_q == TASK_W'(i))
          state_q[i] <= ST_DONE;
        else if (load_ok && res_q == TASK_W'(i))
          state_q[i] <= ST_RUNNING;
        else if (hit_done && a_task == TASK_W'(i))
          state_q[i] <= ST_RUNNING;
      end
      if (launch) begin
        res_q     <= launch_task;
        res_vld_q <= 1'b1;
      end
    end
  end

  // region write port: pass-through or replay
  always_ff @(posedge clk) begin
    if (rst) begin
      rgn_wr    <= 1'b0;
      rgn_waddr <= '0;
      rgn_wdata <= '0;
    end else begin
      rgn_wr <= pass || (load_ok && (cap_vld || fwd));
      if (pass || fwd) begin
        rgn_waddr <= a_reg;
        rgn_wdata <= bus_wdata;
      end else if (load_ok) begin
        rgn_waddr <= cap_reg;
        rgn_wdata <= cap_data;
      end
    end
  end

  // host interrupts and load start
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_irq    <= 1'b0;
      blk_task   <= '0;
      unblk_irq  <= 1'b0;
      unblk_task <= '0;
      cfg_start  <= 1'b0;
      cfg_task   <= '0;
    end else begin
      blk_irq   <= miss;
      unblk_irq <= load_ok;
      cfg_start <= launch;
      if (miss)    blk_task   <= a_task;
      if (load_ok) unblk_task <= res_q;
      if (launch)  cfg_task   <= launch_task;
    end
  end

  // read path
  logic              rd_rgn_q;
  logic [DATA_W-1:0] rgn_word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      rd_rgn_q   <= 1'b0;
      rgn_word_q <= '0;
    end else begin
      bus_rvalid <= rd_v;
      if (rd_v) begin
        rd_rgn_q   <= (st_w == ST_LOADING || st_w == ST_RUNNING ||
                       st_w == ST_DONE);
        rgn_word_q <= rgn_result[a_reg*DATA_W +: DATA_W];
      end
    end
  end

  assign bus_rdata = rd_rgn_q ? rgn_word_q : sh_data;
endmodule

// File: rtl/recfg_task_ctrl_chk.sv
module recfg_task_ctrl_chk #(
  parameter int TASKS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             bus_rvalid,
  input logic             rgn_wr,
  input logic             cfg_done,
  input logic             cfg_start,
  input logic             blk_irq,
  input logic             unblk_irq,
  input logic             push_req,
  input logic             fifo_full,
  input logic [TASKS*3-1:0] st_flat
);
  logic [TASKS-1:0] live;
  always_comb begin
    for (int i = 0; i < TASKS; i++)
      live[i] = (st_flat[i*3 +: 3] == 3'd2) || (st_flat[i*3 +: 3] == 3'd3) ||
                (st_flat[i*3 +: 3] == 3'd4);
  end

  assert_wr_cause_R2: assert property (@(posedge clk) disable iff (rst)
    rgn_wr |-> $past(bus_wr || cfg_done));
  assert_blk_cause_R3: assert property (@(posedge clk) disable iff (rst)
    blk_irq |-> $past(bus_wr));
  assert_start_gap_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_start |=> !cfg_start);
  assert_one_resident_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(live));
  assert_unblk_cause_R6: assert property (@(posedge clk) disable iff (rst)
    unblk_irq |-> $past(cfg_done));
  assert_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    push_req |-> !fifo_full);
endmodule

bind recfg_task_ctrl recfg_task_ctrl_chk #(.TASKS(TASKS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rvalid(bus_rvalid), .rgn_wr(rgn_wr), .cfg_done(cfg_done),
  .cfg_start(cfg_start), .blk_irq(blk_irq), .unblk_irq(unblk_irq),
  .push_req(push_req), .fifo_full(fifo_full), .st_flat(state_q)
);

// File: tb/sim_recfg_task_ctrl.sv
`timescale 1ns/1ps
module sim_recfg_task_ctrl;
  localparam int TASKS = 4, REGS = 4, DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, rgn_fin = 0, cfg_done = 0;
  logic [3:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [REGS*DW-1:0] rgn_result = '0;
  logic [DW-1:0] bus_rdata, rgn_wdata;
  logic bus_rvalid, rgn_wr, cfg_start, blk_irq, unblk_irq;
  logic [1:0] rgn_waddr, cfg_task, blk_task, unblk_task;

  always #2.5 clk = ~clk;

  recfg_task_ctrl #(.TASKS(TASKS), .REGS(REGS), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rgn_wr(rgn_wr), .rgn_waddr(rgn_waddr),
    .rgn_wdata(rgn_wdata), .rgn_result(rgn_result), .rgn_fin(rgn_fin),
    .cfg_start(cfg_start), .cfg_task(cfg_task), .cfg_done(cfg_done),
    .blk_irq(blk_irq), .blk_task(blk_task), .unblk_irq(unblk_irq),
    .unblk_task(unblk_task)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] pat(int t, int run, int r);
    return 32'hA000_0000 + DW'(t*256 + run*16 + r);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic set_res(input int t, input int run);
    for (int r = 0; r < REGS; r++) rgn_result[r*DW +: DW] = pat(t, run, r);
  endtask

  task automatic wr(input int t, input int r, input logic [DW-1:0] d);
    bus_wr = 1; bus_addr = 4'(t*4 + r); bus_wdata = d;
    cyc();
    bus_wr = 0;
  endtask

  task automatic rd(input int t, input int r);
    bus_rd = 1; bus_addr = 4'(t*4 + r);
    cyc();
    bus_rd = 0;
  endtask

  task automatic pulse_done();
    cfg_done = 1; cyc(); cfg_done = 0;
  endtask

  task automatic pulse_fin(input int t, input int run);
    set_res(t, run); rgn_fin = 1; cyc(); rgn_fin = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 rgn_wr", 32'(rgn_wr), 0);
    chk("R1 cfg_start", 32'(cfg_start), 0);
    chk("R1 blk_irq", 32'(blk_irq), 0);
    chk("R1 unblk_irq", 32'(unblk_irq), 0);
    chk("R1 rvalid", 32'(bus_rvalid), 0);

    // R3/R4 miss into idle region: immediate load
    wr(0, 1, 32'h1111_0001);
    chk("R3 blk_irq", 32'(blk_irq), 1);
    chk("R3 blk_task", 32'(blk_task), 0);
    chk("R4 direct cfg_start", 32'(cfg_start), 1);
    chk("R4 cfg_task", 32'(cfg_task), 0);
    cyc();
    chk("R3 blk pulse width", 32'(blk_irq), 0);
    chk("R4 start pulse width", 32'(cfg_start), 0);

    // R4 miss while loading: queued only
    wr(2, 0, 32'h2222_0001);
    chk("R3 blk_irq t2", 32'(blk_irq), 1);
    chk("R3 blk_task t2", 32'(blk_task), 2);
    chk("R4 queued no start", 32'(cfg_start), 0);

    // R9 read of LOADING task comes from region
    set_res(5, 5);
    rd(0, 3);
    chk("R9 rvalid", 32'(bus_rvalid), 1);
    chk("R9 loading from region", bus_rdata, pat(5, 5, 3));

    // R10 writes to LOADING / WAITING tasks
    wr(0, 2, 32'h1111_0002);
    chk("R10 no blk on loading", 32'(blk_irq), 0);
    chk("R10 no rgn_wr on loading", 32'(rgn_wr), 0);
    wr(2, 1, 32'h2222_0002);
    chk("R10 no blk on waiting", 32'(blk_irq), 0);

    // R6 load complete: unblock and replay last write
    pulse_done();
    chk("R6 unblk_irq", 32'(unblk_irq), 1);
    chk("R6 unblk_task", 32'(unblk_task), 0);
    chk("R6 replay wr", 32'(rgn_wr), 1);
    chk("R6 replay addr", 32'(rgn_waddr), 2);
    chk("R10 replay data last", rgn_wdata, 32'h1111_0002);
    cyc();
    chk("R6 unblk pulse width", 32'(unblk_irq), 0);

    // R2 pass-through to RUNNING
    wr(0, 1, 32'hC0C0_0001);
    chk("R2 pass wr", 32'(rgn_wr), 1);
    chk("R2 pass addr", 32'(rgn_waddr), 1);
    chk("R2 pass data", rgn_wdata, 32'hC0C0_0001);
    chk("R2 no blk", 32'(blk_irq), 0);

    // R7/R5 completion, then queued head dispatched
    pulse_fin(0, 0);
    chk("R5 no start at fin edge", 32'(cfg_start), 0);
    cyc();
    chk("R5 dispatch head", 32'(cfg_start), 1);
    chk("R5 dispatch task", 32'(cfg_task), 2);

    // R7/R9 evicted task read from shadow
    set_res(9, 9);
    for (int r = 0; r < REGS; r++) begin
      rd(0, r);
      chk("R7 shadow copy t0", bus_rdata, pat(0, 0, r));
    end

    pulse_done();
    chk("R6 unblk t2", 32'(unblk_task), 2);
    chk("R10 replay addr t2", 32'(rgn_waddr), 1);
    chk("R10 replay data t2", rgn_wdata, 32'h2222_0002);

    // DONE stays resident with empty queue
    pulse_fin(2, 0);
    cyc();
    chk("R5 no start empty queue", 32'(cfg_start), 0);
    set_res(2, 1);
    rd(2, 0);
    chk("R9 DONE from region", bus_rdata, pat(2, 1, 0));

    // R8 write to DONE
    wr(2, 3, 32'hD0D0_0003);
    chk("R8 pass on DONE", 32'(rgn_wr), 1);
    chk("R8 data", rgn_wdata, 32'hD0D0_0003);
    chk("R8 no reload", 32'(cfg_start), 0);
    chk("R8 no blk", 32'(blk_irq), 0);
    pulse_fin(2, 2);
    cyc();

    // R4 direct load evicting DONE task
    wr(1, 0, 32'hE0E0_0000);
    chk("R4 direct blk t1", 32'(blk_task), 1);
    chk("R4 direct start", 32'(cfg_start), 1);
    chk("R4 direct task", 32'(cfg_task), 1);
    set_res(9, 9);
    for (int r = 0; r < REGS; r++) begin
      rd(2, r);
      chk("R9 evicted t2 shadow", bus_rdata, pat(2, 2, r));
    end

    // R5 ordering and R10 no duplicate request
    wr(3, 0, 32'hF0F0_0000);
    chk("R3 blk t3", 32'(blk_task), 3);
    chk("R4 queued t3", 32'(cfg_start), 0);
    wr(0, 0, 32'h6060_0000);
    chk("R3 blk t0", 32'(blk_task), 0);
    wr(3, 2, 32'hF0F0_0002);
    chk("R10 no blk t3 waiting", 32'(blk_irq), 0);

    pulse_done();
    chk("R6 replay t1", rgn_wdata, 32'hE0E0_0000);
    pulse_fin(1, 0);
    cyc();
    chk("R5 order first t3", 32'(cfg_task), 3);
    chk("R5 start t3", 32'(cfg_start), 1);
    pulse_done();
    chk("R6 unblk t3", 32'(unblk_task), 3);
    chk("R10 replay t3 addr", 32'(rgn_waddr), 2);
    chk("R10 replay t3 data", rgn_wdata, 32'hF0F0_0002);
    pulse_fin(3, 0);
    cyc();
    chk("R5 order second t0", 32'(cfg_task), 0);
    chk("R5 start t0", 32'(cfg_start), 1);
    pulse_done();
    chk("R6 replay t0", rgn_wdata, 32'h6060_0000);
    pulse_fin(0, 1);
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R10 no duplicate load", 32'(cfg_start), 0);
    end

    // R9 full sweep: resident t0 from region, others from shadow
    set_res(0, 7);
    for (int t = 0; t < TASKS; t++) begin
      for (int r = 0; r < REGS; r++) begin
        logic [DW-1:0] e;
        case (t)
          0: e = pat(0, 7, r);
          1: e = pat(1, 0, r);
          2: e = pat(2, 2, r);
          default: e = pat(3, 0, r);
        endcase
        rd(t, r);
        chk("R9 sweep", bus_rdata, e);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule